// File: doc/BRIEF.md
# Virtual RAM Boot Window Controller

This block lets a host execute code in place from an 8KB read window while the device is held in reset mode, even though only 2KB of SRAM backs that window. The window is divided into four aligned 2KB segments. One segment at a time is resident in the SRAM, and a tag with a valid flag records which one it is.

A read that falls in the resident segment returns its byte one cycle later. A read that falls elsewhere starts a refill. The controller asks the flash side for the whole missing segment, copies the bytes into the SRAM as they arrive, and holds the active-low busy output low while it does so. When the last byte is stored, the controller finishes the read that missed, on its own, and releases busy.

Outside reset mode the window logic is bypassed: reads are not served and busy stays high.

Top module: `vram_boot_window`

## Requirements
- R1: The window is addressed by `rd_addr[12:0]`. Bits [12:11] select one of four 2KB segments and bits [10:0] select the byte within that segment. A served read returns the flash byte at the full 13-bit address, whether the segment was resident or had to be fetched.
- R2: While `boot_mode` is high and `busy_n` is high, a read that hits the resident segment gives `rd_valid` high for exactly one cycle, on the clock edge after `rd_en` is sampled, with the data on `rd_data`. `busy_n` stays high throughout.
- R3: While `boot_mode` is low, `rd_en` has no effect: `rd_valid` stays low, `busy_n` stays high and `fl_start` stays low.
- R4: A read that misses drives `busy_n` low and pulses `fl_start` high for one cycle, both on the edge after `rd_en` is sampled. On that edge `fl_addr` holds the segment base: bits [12:11] of the read address, with bits [10:0] set to zero.
- R5: During a refill, a byte on `fl_data` is stored only on a cycle where `fl_valid` is high. Bytes are stored in ascending address order, starting at segment offset 0, and the refill ends after 2048 bytes. Cycles with `fl_valid` low leave the sequence paused.
- R6: On the second clock edge after the last refill byte is accepted, `busy_n` returns high. On that same edge `rd_valid` pulses for one cycle with the data of the read that missed.
- R7: While `busy_n` is low, host reads are ignored. They cause no extra `rd_valid` pulse and no extra `fl_start`.
- R8: After a refill completes, the refilled segment is resident. Later reads anywhere in that segment hit. Only one segment is resident at a time.
- R9: A rising edge of `boot_mode` invalidates the resident segment, so the first read after re-entering reset mode misses.
- R10: If `boot_mode` falls during a refill, the refill is abandoned: `busy_n` goes high on the next edge and no `rd_valid` pulse is produced.
- R11: Synchronous active-high `rst` sets `busy_n` high and `rd_valid` and `fl_start` low, and leaves no segment resident.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_mode | input | 1 | High while the device is in reset mode (virtual RAM active) |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 13 | Host byte address in the window |
| rd_data | output | 8 | Read data, qualified by rd_valid |
| rd_valid | output | 1 | One-cycle pulse when rd_data holds the requested byte |
| busy_n | output | 1 | Active-low busy, low for the duration of a refill |
| fl_start | output | 1 | One-cycle pulse requesting a segment from flash |
| fl_addr | output | 13 | Base address of the requested segment |
| fl_data | input | 8 | Byte from flash |
| fl_valid | input | 1 | fl_data carries the next byte of the segment |

## Verification
The assertions take the flash side to behave: it raises `fl_valid` only after a request and supplies the segment bytes in order. They also take `boot_mode` to change synchronously to `clk`. The bench respects both. Its flash model drives bytes only after it has seen `fl_start`, stops after exactly 2048 bytes, and inserts idle cycles only as paused beats. All inputs change on the falling edge, and `boot_mode` is toggled only while the block is idle, except in the deliberate abort scenario.

// File: rtl/vrb_pkg.sv
package vrb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_FETCH = 2'd2
  } vrb_state_e;
endpackage

// File: rtl/vrb_sram.sv
// Simple dual-port store: one write port, one registered read port.
module vrb_sram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/vrb_tag.sv
// Residency record: which segment sits in the SRAM, and whether it is valid.
module vrb_tag #(
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          load,
  input  logic [TW-1:0] load_tag,
  input  logic [TW-1:0] probe_tag,
  output logic          hit
);
  logic          valid_q;
  logic [TW-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      tag_q   <= load_tag;
    end
  end

  assign hit = valid_q && (tag_q == probe_tag);
endmodule

// File: rtl/vrb_refill.sv
// Miss detection, refill sequencing and the busy handshake.
module vrb_refill
  import vrb_pkg::*;
#(
  parameter int WIN_AW = 13,
  parameter int SEG_AW = 11
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     boot_mode,
  input  logic                     rd_en,
  input  logic [WIN_AW-1:0]        rd_addr,
  input  logic                     hit,
  input  logic                     fl_valid,
  output logic                     tag_clr,
  output logic                     tag_load,
  output logic [WIN_AW-SEG_AW-1:0] load_tag,
  output logic                     ram_we,
  output logic [SEG_AW-1:0]        ram_waddr,
  output logic [SEG_AW-1:0]        ram_raddr,
  output logic                     rd_valid,
  output logic                     busy_n,
  output logic                     fl_start,
  output logic [WIN_AW-1:0]        fl_addr
);
  localparam int TW = WIN_AW - SEG_AW;

  vrb_state_e         state_q;
  logic [SEG_AW-1:0]  cnt_q;
  logic [WIN_AW-1:0]  pend_q;
  logic               boot_q;
  logic               boot_rise;
  logic               accept;
  logic               take_hit;
  logic               take_miss;
  logic               last_byte;

  assign boot_rise = boot_mode && !boot_q;
  assign tag_clr   = boot_rise;
  assign accept    = boot_mode && rd_en && (state_q == ST_IDLE);
  assign take_hit  = accept && hit && !boot_rise;
  assign take_miss = accept && !(hit && !boot_rise);

  assign ram_we    = (state_q == ST_FILL) && fl_valid;
  assign ram_waddr = cnt_q;
  assign last_byte = ram_we && (cnt_q == {SEG_AW{1'b1}});
  assign tag_load  = last_byte && boot_mode;
  assign load_tag  = pend_q[WIN_AW-1:SEG_AW];
  assign ram_raddr = (state_q == ST_FETCH) ? pend_q[SEG_AW-1:0] : rd_addr[SEG_AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      pend_q   <= '0;
      boot_q   <= 1'b0;
      rd_valid <= 1'b0;
      busy_n   <= 1'b1;
      fl_start <= 1'b0;
      fl_addr  <= '0;
    end else begin
      boot_q   <= boot_mode;
      rd_valid <= 1'b0;
      fl_start <= 1'b0;
      if (!boot_mode) begin
        state_q <= ST_IDLE;
        busy_n  <= 1'b1;
      end else begin
        case (state_q)
          ST_IDLE: begin
            if (take_hit) begin
              rd_valid <= 1'b1;
            end else if (take_miss) begin
              pend_q   <= rd_addr;
              fl_addr  <= {rd_addr[WIN_AW-1:SEG_AW], {SEG_AW{1'b0}}};
              fl_start <= 1'b1;
              busy_n   <= 1'b0;
              cnt_q    <= '0;
              state_q  <= ST_FILL;
            end
          end
          ST_FILL: begin
            if (ram_we) begin
              cnt_q <= cnt_q + 1'b1;
              if (last_byte) state_q <= ST_FETCH;
            end
          end
          ST_FETCH: begin
            rd_valid <= 1'b1;
            busy_n   <= 1'b1;
            state_q  <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  logic [TW-1:0] unused_tw;
  assign unused_tw = '0;
endmodule

// File: rtl/vram_boot_window.sv
module vram_boot_window #(
  parameter int WIN_AW = 13,
  parameter int SEG_AW = 11,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_mode,
  input  logic              rd_en,
  input  logic [WIN_AW-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid,
  output logic              busy_n,
  output logic              fl_start,
  output logic [WIN_AW-1:0] fl_addr,
  input  logic [DW-1:0]     fl_data,
  input  logic              fl_valid
);
  localparam int TW = WIN_AW - SEG_AW;

  logic              hit;
  logic              tag_clr;
  logic              tag_load;
  logic [TW-1:0]     load_tag;
  logic              ram_we;
  logic [SEG_AW-1:0] ram_waddr;
  logic [SEG_AW-1:0] ram_raddr;

  vrb_tag #(.TW(TW)) u_tag (
    .clk       (clk),
    .rst       (rst),
    .clr       (tag_clr),
    .load      (tag_load),
    .load_tag  (load_tag),
    .probe_tag (rd_addr[WIN_AW-1:SEG_AW]),
    .hit       (hit)
  );

  vrb_refill #(.WIN_AW(WIN_AW), .SEG_AW(SEG_AW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .boot_mode (boot_mode),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .hit       (hit),
    .fl_valid  (fl_valid),
    .tag_clr   (tag_clr),
    .tag_load  (tag_load),
    .load_tag  (load_tag),
    .ram_we    (ram_we),
    .ram_waddr (ram_waddr),
    .ram_raddr (ram_raddr),
    .rd_valid  (rd_valid),
    .busy_n    (busy_n),
    .fl_start  (fl_start),
    .fl_addr   (fl_addr)
  );

  vrb_sram #(.AW(SEG_AW), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (fl_data),
    .raddr (ram_raddr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/vrb_checker.sv
module vrb_checker #(
  parameter int WIN_AW = 13,
  parameter int SEG_AW = 11,
  parameter int DW     = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              boot_mode,
  input logic              rd_en,
  input logic [WIN_AW-1:0] rd_addr,
  input logic [DW-1:0]     rd_data,
  input logic              rd_valid,
  input logic              busy_n,
  input logic              fl_start,
  input logic [WIN_AW-1:0] fl_addr,
  input logic [DW-1:0]     fl_data,
  input logic              fl_valid
);
  p_bypass_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !boot_mode |=> busy_n);

  p_bypass_no_read_r3: assert property (@(posedge clk) disable iff (rst)
    !boot_mode |=> !rd_valid && !fl_start);

  p_start_with_busy_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_n) |-> fl_start);

  p_start_aligned_r4: assert property (@(posedge clk) disable iff (rst)
    fl_start |-> (fl_addr[SEG_AW-1:0] == '0) && !busy_n);

  p_start_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    fl_start |=> !fl_start);

  p_release_with_data_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_n) && $past(boot_mode) |-> rd_valid);

  p_quiet_while_busy_r7: assert property (@(posedge clk) disable iff (rst)
    !busy_n |-> !rd_valid);

  p_read_answered_r2: assert property (@(posedge clk) disable iff (rst)
    rd_en && busy_n && boot_mode |=> rd_valid || !busy_n);

  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
endmodule

bind vram_boot_window vrb_checker #(.WIN_AW(WIN_AW), .SEG_AW(SEG_AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .boot_mode (boot_mode),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .busy_n    (busy_n),
  .fl_start  (fl_start),
  .fl_addr   (fl_addr),
  .fl_data   (fl_data),
  .fl_valid  (fl_valid)
);

// File: tb/vram_boot_window_bench.sv
module vram_boot_window_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SEG_BYTES  = 2048;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        boot_mode = 1'b0;
  logic        rd_en = 1'b0;
  logic [12:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic        busy_n;
  logic        fl_start;
  logic [12:0] fl_addr;
  logic [7:0]  fl_data = '0;
  logic        fl_valid = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vram_boot_window u_vram_boot_window (
    .clk(clk), .rst(rst), .boot_mode(boot_mode), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy_n(busy_n), .fl_start(fl_start),
    .fl_addr(fl_addr), .fl_data(fl_data), .fl_valid(fl_valid)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 13) + ((a >> 8) * 7) + 5);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Hit: data one edge after the strobe, busy untouched (R2, R8).
  task automatic hit_read(input int addr);
    rd_en = 1'b1; rd_addr = 13'(addr);
    @(negedge clk);
    rd_en = 1'b0;
    check(rd_valid && busy_n && !fl_start, "R2", "hit handshake",
          {rd_valid, busy_n, fl_start}, 3'b110);
    check(rd_data == pat(addr), "R8", "hit data", rd_data, pat(addr));
    @(negedge clk);
    check(!rd_valid, "R2", "valid pulse width", rd_valid, 0);
  endtask

  // Miss with full refill; optional idle beats (R5) and stray reads (R7).
  task automatic miss_read(input int addr, input bit gaps, input bit stray);
    int base = addr & 13'h1800;
    int bad = 0;
    rd_en = 1'b1; rd_addr = 13'(addr);
    @(negedge clk);
    rd_en = 1'b0;
    check(!busy_n && fl_start && !rd_valid, "R4", "miss start",
          {busy_n, fl_start, rd_valid}, 3'b010);
    check(fl_addr == 13'(base), "R4", "segment base", fl_addr, base);
    for (int i = 0; i < SEG_BYTES; i++) begin
      if (gaps && (i % 5 == 2)) begin
        fl_valid = 1'b0;
        fl_data  = 8'hA5;
        @(negedge clk);
        if (rd_valid || fl_start) bad++;
      end
      fl_valid = 1'b1;
      fl_data  = pat(base + i);
      if (stray && (i == 100 || i == 101)) begin
        rd_en = 1'b1; rd_addr = 13'(addr ^ 13'h0800);
      end else begin
        rd_en = 1'b0;
      end
      @(negedge clk);
      if (rd_valid || fl_start || busy_n) bad++;
    end
    fl_valid = 1'b0;
    rd_en = 1'b0;
    check(bad == 0, stray ? "R7" : "R5", "quiet during refill", bad, 0);
    check(!busy_n && !rd_valid, "R6", "busy one edge after last byte",
          {busy_n, rd_valid}, 2'b00);
    @(negedge clk);
    check(busy_n && rd_valid, "R6", "release with data", {busy_n, rd_valid}, 2'b11);
    check(rd_data == pat(addr), "R1", "miss data", rd_data, pat(addr));
    @(negedge clk);
    check(!rd_valid && busy_n, "R6", "after release", {rd_valid, busy_n}, 2'b01);
  endtask

  task automatic test_reset();
    check(busy_n && !rd_valid && !fl_start, "R11", "reset outputs",
          {busy_n, rd_valid, fl_start}, 3'b100);
  endtask

  task automatic test_bypass();
    boot_mode = 1'b0;
    rd_en = 1'b1; rd_addr = 13'h0123;
    @(negedge clk);
    rd_en = 1'b0;
    check(!rd_valid && busy_n && !fl_start, "R3", "bypass read",
          {rd_valid, busy_n, fl_start}, 3'b010);
    @(negedge clk);
    check(!rd_valid && busy_n && !fl_start, "R3", "bypass quiet",
          {rd_valid, busy_n, fl_start}, 3'b010);
  endtask

  task automatic enter_boot();
    boot_mode = 1'b1;
    @(negedge clk);
  endtask

  task automatic test_reentry();
    boot_mode = 1'b0;
    @(negedge clk);
    @(negedge clk);
    enter_boot();
    // R9: segment 0 was resident; first read after re-entry must miss.
    rd_en = 1'b1; rd_addr = 13'h0020;
    @(negedge clk);
    rd_en = 1'b0;
    check(fl_start && !busy_n, "R9", "miss after re-entry", {fl_start, busy_n}, 2'b10);
    for (int i = 0; i < SEG_BYTES; i++) begin
      fl_valid = 1'b1; fl_data = pat(i);
      @(negedge clk);
    end
    fl_valid = 1'b0;
    @(negedge clk);
    check(rd_valid && rd_data == pat(32'h20), "R9", "re-entry refill data",
          rd_data, pat(32'h20));
    @(negedge clk);
  endtask

  task automatic test_abort();
    rd_en = 1'b1; rd_addr = 13'h0900;
    @(negedge clk);
    rd_en = 1'b0;
    check(fl_start && !busy_n, "R10", "abort setup miss", {fl_start, busy_n}, 2'b10);
    for (int i = 0; i < 50; i++) begin
      fl_valid = 1'b1; fl_data = pat(32'h0800 + i);
      @(negedge clk);
    end
    fl_valid = 1'b0;
    boot_mode = 1'b0;
    @(negedge clk);
    check(busy_n && !rd_valid, "R10", "abort releases busy", {busy_n, rd_valid}, 2'b10);
    @(negedge clk);
    check(busy_n && !rd_valid && !fl_start, "R10", "abort stays quiet",
          {busy_n, rd_valid, fl_start}, 3'b100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_bypass();
    enter_boot();
    miss_read(32'h0123, 1'b0, 1'b0);   // R1, R4, R6
    hit_read(32'h0000);                // R8
    hit_read(32'h07FF);
    hit_read(32'h0400);
    miss_read(32'h1A55, 1'b1, 1'b1);   // R5, R7
    hit_read(32'h1800);
    hit_read(32'h1FFF);
    miss_read(32'h0010, 1'b0, 1'b0);   // R8: only one segment resident
    hit_read(32'h0123);
    test_reentry();                    // R9
    test_abort();                      // R10
    test_bypass();                     // R3 again after abort
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule